// File: doc/BRIEF.md
# Protection Key Access Checker

This block holds the key-rights register of one hardware thread and judges each memory access against it. Every page carries a small key number in its page-table entry. The requester presents that key with the access kind and the long-mode flag. The block looks up the two rights bits for the key and returns a registered allow or fault verdict one cycle later.

The verdict comes back with the key and the access kind that produced it. Only data reads and data writes can fault. Instruction fetches, and every access made outside long mode, always pass.

Software reads and writes the rights register through a dedicated port that has no privilege gating. A write takes effect on the next clock edge, so an access checked in the same cycle as the write still sees the old rights.

Top module: `keyperm_checker`

## Requirements
- R1: After reset the rights register reads all zeros, `resp_valid` is 0 and `resp_fault` is 0. With all-zero rights, every key allows every access.
- R2: When `rr_wr_en` is 1 at a clock edge, `rr_rd_data` shows `rr_wr_data` from that edge on. Writes have no privilege gating. With `rr_wr_en` at 0 the register holds its value.
- R3: `resp_valid` is 1 exactly in the cycle after a cycle with `req_valid` at 1. In that cycle `resp_key` and `resp_kind` equal the `req_key` and `req_kind` of the request.
- R4: Key k's access-disable bit is register bit 2k. With it set and `req_long` at 1, a data read (`req_kind` = 0) and a data write (`req_kind` = 1) with key k both fault.
- R5: Key k's write-disable bit is register bit 2k+1. With only that bit set and `req_long` at 1, a data write with key k faults and a data read with key k is allowed.
- R6: An instruction fetch (`req_kind` = 2), and the unused kind code 3, never fault, whatever the register holds.
- R7: With `req_long` at 0, no access faults, whatever the register holds.
- R8: A request in the same cycle as a register write is judged against the register value from before that write.
- R9: `resp_fault` is 0 in every cycle in which `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_wr_en | input | 1 | Rights register write strobe |
| rr_wr_data | input | 32 | New rights value (2 bits per key) |
| rr_rd_data | output | 32 | Current rights value |
| req_valid | input | 1 | Access request present |
| req_key | input | 4 | Protection key of the target page |
| req_kind | input | 2 | 0 data read, 1 data write, 2 fetch, 3 unused |
| req_long | input | 1 | Long-mode flag; the check is active only when 1 |
| resp_valid | output | 1 | Verdict present (one cycle after request) |
| resp_fault | output | 1 | 1 when the access faults |
| resp_key | output | 4 | Key of the judged request |
| resp_kind | output | 2 | Kind of the judged request |

## Verification
The bench builds the block with its default key width of 4 bits. That gives 16 keys and a 32-bit rights register, so every key and every bit position can be reached in a short run. Random register values and random requests, including writes in the same cycle as requests, cover all key and kind combinations in both modes. Directed cases pin down each rights-bit position, writes in the same cycle as requests, and the fetch and legacy-mode bypasses.

// File: rtl/keyperm_pkg.sv
package keyperm_pkg;

  typedef enum logic [1:0] {
    ACC_DREAD  = 2'd0,
    ACC_DWRITE = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_SPARE  = 2'd3
  } acc_kind_e;

  // True for the access kinds that the key rights govern.
  function automatic logic is_data_kind(input logic [1:0] kind);
    return (kind == ACC_DREAD) || (kind == ACC_DWRITE);
  endfunction

  // Verdict from the two rights bits of one key.
  function automatic logic rights_deny(input logic ad, input logic wd,
                                       input logic [1:0] kind);
    logic deny;
    case (kind)
      ACC_DREAD:  deny = ad;
      ACC_DWRITE: deny = ad | wd;
      default:    deny = 1'b0;
    endcase
    return deny;
  endfunction

endpackage

// File: rtl/keyperm_rights_reg.sv
module keyperm_rights_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)
      q_r <= '0;
    else if (wr_en)
      q_r <= wr_data;
  end

  assign q = q_r;

endmodule

// File: rtl/keyperm_lookup.sv
module keyperm_lookup
  import keyperm_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int REG_W = 2 * NUM_KEYS
) (
  input  logic [REG_W-1:0] rights,
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       kind,
  input  logic             long_mode,
  output logic             enforce,
  output logic             fault
);

  logic [NUM_KEYS-1:0] ad_vec;
  logic [NUM_KEYS-1:0] wd_vec;

  // Split the packed register into one vector per rights bit.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
    assign ad_vec[k] = rights[2*k];
    assign wd_vec[k] = rights[2*k+1];
  end

  logic sel_ad;
  logic sel_wd;

  assign sel_ad  = ad_vec[key];
  assign sel_wd  = wd_vec[key];
  assign enforce = long_mode & is_data_kind(kind);
  assign fault   = enforce & rights_deny(sel_ad, sel_wd, kind);

endmodule

// File: rtl/keyperm_resp_stage.sv
module keyperm_resp_stage #(
  parameter int KEY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_fault,
  input  logic [KEY_W-1:0] in_key,
  input  logic [1:0]       in_kind,
  output logic             out_valid,
  output logic             out_fault,
  output logic [KEY_W-1:0] out_key,
  output logic [1:0]       out_kind
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_key   <= '0;
      out_kind  <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid & in_fault;
      if (in_valid) begin
        out_key  <= in_key;
        out_kind <= in_kind;
      end
    end
  end

endmodule

// File: rtl/keyperm_checker.sv
module keyperm_checker #(
  parameter int KEY_W = 4,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int REG_W = 2 * NUM_KEYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_wr_en,
  input  logic [REG_W-1:0] rr_wr_data,
  output logic [REG_W-1:0] rr_rd_data,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_key,
  input  logic [1:0]       req_kind,
  input  logic             req_long,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [KEY_W-1:0] resp_key,
  output logic [1:0]       resp_kind
);

  logic [REG_W-1:0] rights_q;
  logic             chk_enforce;
  logic             chk_fault;

  keyperm_rights_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rr_wr_en),
    .wr_data (rr_wr_data),
    .q       (rights_q)
  );

  // The lookup reads the register output, so a write in this cycle is not yet seen.
  keyperm_lookup #(.KEY_W(KEY_W)) u_lookup (
    .rights    (rights_q),
    .key       (req_key),
    .kind      (req_kind),
    .long_mode (req_long),
    .enforce   (chk_enforce),
    .fault     (chk_fault)
  );

  keyperm_resp_stage #(.KEY_W(KEY_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_fault  (chk_fault),
    .in_key    (req_key),
    .in_kind   (req_kind),
    .out_valid (resp_valid),
    .out_fault (resp_fault),
    .out_key   (resp_key),
    .out_kind  (resp_kind)
  );

  assign rr_rd_data = rights_q;

endmodule

// File: rtl/keyperm_checker_sva.sv
module keyperm_checker_sva #(
  parameter int KEY_W = 4,
  localparam int NUM_KEYS = 1 << KEY_W,
  localparam int REG_W = 2 * NUM_KEYS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rr_wr_en,
  input logic [REG_W-1:0] rr_wr_data,
  input logic [REG_W-1:0] rr_rd_data,
  input logic             req_valid,
  input logic [KEY_W-1:0] req_key,
  input logic [1:0]       req_kind,
  input logic             req_long,
  input logic             resp_valid,
  input logic             resp_fault,
  input logic [KEY_W-1:0] resp_key,
  input logic [1:0]       resp_kind,
  input logic             chk_enforce,
  input logic             chk_fault
);

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rr_wr_en |=> rr_rd_data == $past(rr_wr_data));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_wr_en |=> $stable(rr_rd_data));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  p_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (resp_key == $past(req_key)) && (resp_kind == $past(req_kind)));

  // R4 and R8: the rights bits are taken from the register value before any write in this cycle.
  p_ad_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_long && (req_kind < 2'd2) && rr_rd_data[{req_key, 1'b0}]
    |=> resp_fault);

  p_wd_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_long && (req_kind == 2'd1) && rr_rd_data[{req_key, 1'b1}]
    |=> resp_fault);

  p_rd_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_kind == 2'd0) && !rr_rd_data[{req_key, 1'b0}]
    |=> !resp_fault);

  p_fetch_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_kind[1] |-> !resp_fault);

  p_legacy_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_long |=> !resp_fault);

  p_lookup_to_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && chk_fault |=> resp_fault);

  p_enforce_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_enforce |-> !chk_fault);

  p_fault_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_fault);

endmodule

bind keyperm_checker keyperm_checker_sva #(.KEY_W(KEY_W)) u_sva (.*);

// File: tb/sim_keyperm_checker.sv
module sim_keyperm_checker;

  localparam int KW = 4;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rr_wr_en = 1'b0;
  logic [RW-1:0] rr_wr_data = '0;
  logic [RW-1:0] rr_rd_data;
  logic          req_valid = 1'b0;
  logic [KW-1:0] req_key = '0;
  logic [1:0]    req_kind = '0;
  logic          req_long = 1'b0;
  logic          resp_valid;
  logic          resp_fault;
  logic [KW-1:0] resp_key;
  logic [1:0]    resp_kind;

  int checks = 0;
  int errors = 0;
  logic [RW-1:0] model = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  keyperm_checker #(.KEY_W(KW)) u0 (.*);

  function automatic bit want_fault(logic [RW-1:0] r, logic [KW-1:0] k,
                                    logic [1:0] kind, logic lm);
    bit ad, wd;
    ad = r[k*2];
    wd = r[k*2+1];
    if (!lm || kind[1]) return 1'b0;
    if (kind == 2'd1) return ad || wd;
    return ad;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check just after the rising edge.
  task automatic step(bit v, logic [KW-1:0] k, logic [1:0] kind, bit lm,
                      bit we, logic [RW-1:0] wd, string tag);
    bit ef;
    logic [RW-1:0] next;
    @(negedge clk);
    req_valid = v; req_key = k; req_kind = kind; req_long = lm;
    rr_wr_en = we; rr_wr_data = wd;
    ef = v && want_fault(model, k, kind, lm);
    next = we ? wd : model;
    @(posedge clk);
    #1;
    check({tag, " R3 valid"}, resp_valid, v);
    check({tag, " R9/R4-R8 fault"}, resp_fault, ef);
    if (v) begin
      check({tag, " R3 key"}, resp_key, k);
      check({tag, " R3 kind"}, resp_kind, kind);
    end
    check({tag, " R2 readback"}, rr_rd_data, next);
    model = next;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2015);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 rights", rr_rd_data, 0);
    check("R1 valid", resp_valid, 0);
    check("R1 fault", resp_fault, 0);
    @(negedge clk) rst_n = 1'b1;
    // R1: zero rights allow everything
    step(1, 4'd3, 2'd1, 1, 0, '0, "R1 open");
    // R4: access disable on key 5 (bit 10)
    step(0, 0, 0, 0, 1, 32'h1 << 10, "R2 wr");
    step(1, 4'd5, 2'd0, 1, 0, '0, "R4 rd");
    step(1, 4'd5, 2'd1, 1, 0, '0, "R4 wr");
    step(1, 4'd4, 2'd1, 1, 0, '0, "R4 other key");
    // R5: write disable only on key 9 (bit 19)
    step(0, 0, 0, 0, 1, 32'h1 << 19, "R2 wr");
    step(1, 4'd9, 2'd0, 1, 0, '0, "R5 rd");
    step(1, 4'd9, 2'd1, 1, 0, '0, "R5 wr");
    // R6: fetch and spare kind with all rights denied
    step(0, 0, 0, 0, 1, '1, "R2 wr");
    step(1, 4'd9, 2'd2, 1, 0, '0, "R6 fetch");
    step(1, 4'd0, 2'd3, 1, 0, '0, "R6 spare");
    // R7: legacy mode with all rights denied
    step(1, 4'd7, 2'd1, 0, 0, '0, "R7 legacy");
    step(1, 4'd15, 2'd0, 1, 0, '0, "R4 key15");
    // R8: same-cycle write clears rights but old value judges
    step(1, 4'd2, 2'd0, 1, 1, '0, "R8 old");
    step(1, 4'd2, 2'd0, 1, 0, '0, "R8 new");
    step(1, 4'd2, 2'd1, 1, 1, '1, "R8 old2");
    step(1, 4'd2, 2'd1, 1, 0, '0, "R8 new2");
    // R9: idle cycle
    step(0, 4'd2, 2'd1, 1, 0, '0, "R9 idle");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, KW'($urandom), 2'($urandom),
           $urandom_range(0, 4) != 0, $urandom_range(0, 5) == 0,
           $urandom, "R4/R5 random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule